// File: doc/BRIEF.md
# Circular Multi-Buffer Region Manager

This block tracks ownership of a shared memory region split into a parameterised number of equal-sized buffers, passed between one producer (writer) and one consumer (reader). It gives the producer the index and byte address of the buffer it should fill next. It gives the consumer the index and byte address of the oldest buffer that has been completely filled. Neither side moves any data through the block. Each side reports that it has finished its current buffer with a one-cycle done pulse, and the block then advances that side's pointer around the ring.

Full and empty are told apart by a count of filled buffers, not by comparing the two pointers. The same logic therefore covers three cases:
- With one buffer, write and read strictly alternate.
- With two buffers, the pair works as a ping-pong.
- With more buffers, it runs as a ring.

A side with nothing available sees its available flag low and must wait. Done pulses that arrive while a side is stalled are ignored. The faster side is thereby held to the rate of the slower one.

Top module: `ring_buf_mgr`

## Requirements
- R1: After reset, the write and read indices are 0, wr_avail_o is 1, rd_avail_o is 0 and fill_cnt_o is 0.
- R2: An address output equals BASE_ADDR + index * BUF_BYTES. The region spans NUM_BUFS * BUF_BYTES bytes.
- R3: A wr_done_i pulse while wr_avail_o is 1 advances the write index by one, wrapping from NUM_BUFS-1 to 0, and increments fill_cnt_o in the next cycle.
- R4: A rd_done_i pulse while rd_avail_o is 1 advances the read index by one, wrapping from NUM_BUFS-1 to 0, and decrements fill_cnt_o in the next cycle.
- R5: A buffer becomes readable only after its write-done pulse. rd_avail_o equals (fill_cnt_o != 0).
- R6: When all NUM_BUFS buffers are filled, wr_avail_o is 0. A wr_done_i pulse in that state changes neither the write index nor the fill count.
- R7: When no buffer is filled, a rd_done_i pulse changes neither the read index nor the fill count.
- R8: Accepted write-done and read-done pulses in the same cycle advance both indices and leave fill_cnt_o unchanged.
- R9: With NUM_BUFS = 1, the sequence is strictly write then read. With NUM_BUFS = 2, the writer may fill buffer 1 while buffer 0 awaits reading.
- R10: Parameter legality: BUF_BYTES is a whole multiple of both WR_BURST_BYTES and RD_BURST_BYTES, bursts per buffer do not exceed 5000, and NUM_BUFS lies in 3..64 when DMA_MODE is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_done_i | input | 1 | Writer finished its current buffer |
| rd_done_i | input | 1 | Reader finished its current buffer |
| wr_avail_o | output | 1 | A free buffer exists for the writer |
| rd_avail_o | output | 1 | A filled buffer exists for the reader |
| wr_idx_o | output | IDX_W | Buffer index the writer should fill |
| rd_idx_o | output | IDX_W | Buffer index the reader should drain |
| wr_addr_o | output | ADDR_W | Byte address of the writer's buffer |
| rd_addr_o | output | ADDR_W | Byte address of the reader's buffer |
| fill_cnt_o | output | CNT_W | Number of filled buffers |

## Verification
The bench targets five corner cases:
- **Full ring.** A design that compared only the two pointers would mistake a full ring for an empty one. It would then let the writer overwrite unread data, or report nothing to read.
- **Done pulses while stalled.** Pulses on a blocked side are driven to confirm they are dropped. A design that accepted them would skew the pointers.
- **Simultaneous done pulses.** Both sides pulse in the same cycle. An error here shows as a drifting fill count.
- **Index wrap.** Both indices are walked past the last buffer to confirm they return to 0.
- **Small rings.** Separate instances with one and two buffers check strict alternation and ping-pong. These are the cases where an off-by-one in the full test would surface.

// File: rtl/ring_buf_pkg.sv
package ring_buf_pkg;
  localparam int unsigned MAX_BURSTS_PER_BUF = 5000;
  localparam int unsigned DMA_MIN_BUFS = 3;
  localparam int unsigned DMA_MAX_BUFS = 64;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int unsigned NUM_BUFS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUFS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);                                          // R3
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST) |=> idx_q == '0);             // R4
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));                             // R6
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
  parameter int unsigned NUM_BUFS = 4,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic             rd_req_i,
  output logic             wr_ok_o,
  output logic             rd_ok_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BUFS);

  logic [CNT_W-1:0] cnt_q;
  logic wr_acc, rd_acc;

  assign wr_ok_o = (cnt_q != FULL);
  assign rd_ok_o = (cnt_q != '0);
  assign wr_acc  = wr_req_i && wr_ok_o;
  assign rd_acc  = rd_req_i && rd_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({wr_acc, rd_acc})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);                                          // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL && wr_req_i && !rd_req_i) |=> cnt_q == FULL); // R6
  AST_EMPTY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && rd_req_i && !wr_req_i) |=> cnt_q == '0);     // R7
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && rd_acc) |=> $stable(cnt_q));                  // R8
endmodule

// File: rtl/ring_buf_mgr.sv
module ring_buf_mgr
  import ring_buf_pkg::*;
#(
  parameter int unsigned NUM_BUFS       = 4,
  parameter int unsigned BUF_BYTES      = 1024,
  parameter int unsigned WR_BURST_BYTES = 256,
  parameter int unsigned RD_BURST_BYTES = 128,
  parameter int unsigned ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter bit          DMA_MODE       = 1'b0,
  localparam int unsigned IDX_W = idx_width(NUM_BUFS),
  localparam int unsigned CNT_W = $clog2(NUM_BUFS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_done_i,
  input  logic              rd_done_i,
  output logic              wr_avail_o,
  output logic              rd_avail_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0]  fill_cnt_o
);
  localparam longint unsigned REGION_BYTES = longint'(NUM_BUFS) * BUF_BYTES;
  localparam logic [ADDR_W-1:0] BUF_STRIDE = ADDR_W'(BUF_BYTES);

  // R10 parameter legality
  initial begin
    assert (NUM_BUFS >= 1);
    assert (BUF_BYTES % WR_BURST_BYTES == 0);
    assert (BUF_BYTES % RD_BURST_BYTES == 0);
    assert (BUF_BYTES / WR_BURST_BYTES <= MAX_BURSTS_PER_BUF);
    assert (BUF_BYTES / RD_BURST_BYTES <= MAX_BURSTS_PER_BUF);
    assert (!DMA_MODE || (NUM_BUFS >= DMA_MIN_BUFS && NUM_BUFS <= DMA_MAX_BUFS));
    assert (REGION_BYTES <= (64'd1 << ADDR_W));
  end

  logic wr_ok, rd_ok;

  fill_tracker #(.NUM_BUFS(NUM_BUFS), .CNT_W(CNT_W)) u_fill (
    .clk_i, .rst_ni,
    .wr_req_i(wr_done_i), .rd_req_i(rd_done_i),
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok), .cnt_o(fill_cnt_o)
  );

  ring_ptr #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_wr_ptr (
    .clk_i, .rst_ni, .step_i(wr_done_i && wr_ok), .idx_o(wr_idx_o)
  );

  ring_ptr #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_rd_ptr (
    .clk_i, .rst_ni, .step_i(rd_done_i && rd_ok), .idx_o(rd_idx_o)
  );

  assign wr_avail_o = wr_ok;
  assign rd_avail_o = rd_ok;
  assign wr_addr_o  = BASE_ADDR + ADDR_W'(wr_idx_o) * BUF_STRIDE;
  assign rd_addr_o  = BASE_ADDR + ADDR_W'(rd_idx_o) * BUF_STRIDE;

  AST_EMPTY_SAME_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_cnt_o == '0) |-> (wr_idx_o == rd_idx_o));          // R5
  AST_RD_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_avail_o) |-> $past(wr_done_i));                 // R5
  AST_WR_STALL_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_avail_o && wr_done_i) |=> $stable(wr_idx_o));       // R6
  AST_RD_STALL_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_avail_o && rd_done_i) |=> $stable(rd_idx_o));       // R7
endmodule

// File: tb/ring_buf_mgr_bench.sv
module ring_buf_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int BB = 1024;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic wd = 0, rd = 0;
  logic wd1 = 0, rd1 = 0, wd2 = 0, rd2 = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic        wa, ra;
  logic [1:0]  wi, ri;
  logic [31:0] waddr, raddr;
  logic [2:0]  fc;

  ring_buf_mgr #(.NUM_BUFS(N), .BUF_BYTES(BB), .BASE_ADDR(BASE), .DMA_MODE(1'b1)) u_ring_buf_mgr (
    .clk_i(clk), .rst_ni(rst_n), .wr_done_i(wd), .rd_done_i(rd),
    .wr_avail_o(wa), .rd_avail_o(ra), .wr_idx_o(wi), .rd_idx_o(ri),
    .wr_addr_o(waddr), .rd_addr_o(raddr), .fill_cnt_o(fc));

  logic a1w, a1r; logic [0:0] i1w, i1r; logic [31:0] ad1w, ad1r; logic [0:0] c1;
  ring_buf_mgr #(.NUM_BUFS(1), .BUF_BYTES(256)) u_one (
    .clk_i(clk), .rst_ni(rst_n), .wr_done_i(wd1), .rd_done_i(rd1),
    .wr_avail_o(a1w), .rd_avail_o(a1r), .wr_idx_o(i1w), .rd_idx_o(i1r),
    .wr_addr_o(ad1w), .rd_addr_o(ad1r), .fill_cnt_o(c1));

  logic a2w, a2r; logic [0:0] i2w, i2r; logic [31:0] ad2w, ad2r; logic [1:0] c2;
  ring_buf_mgr #(.NUM_BUFS(2), .BUF_BYTES(512)) u_two (
    .clk_i(clk), .rst_ni(rst_n), .wr_done_i(wd2), .rd_done_i(rd2),
    .wr_avail_o(a2w), .rd_avail_o(a2r), .wr_idx_o(i2w), .rd_idx_o(i2r),
    .wr_addr_o(ad2w), .rd_addr_o(ad2r), .fill_cnt_o(c2));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive pulse for one cycle; inputs change at negedge
  task automatic pulse(input bit w, input bit r);
    wd = w; rd = r;
    @(negedge clk);
    wd = 0; rd = 0;
  endtask

  task automatic chk_state(input string req, input int ewi, input int eri, input int efc);
    chk(req, wi, ewi);
    chk(req, ri, eri);
    chk(req, fc, efc);
    chk(req, wa, efc != N);
    chk(req, ra, efc != 0);
    chk(req, waddr, BASE + ewi * BB);
    chk(req, raddr, BASE + eri * BB);
  endtask

  task automatic t_reset;
    chk_state("R1", 0, 0, 0);
    chk("R1", a1w, 1); chk("R1", a1r, 0);
  endtask

  task automatic t_fill_and_block;
    pulse(1, 0); chk_state("R3", 1, 0, 1);
    chk("R5", ra, 1);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    chk_state("R6", 0, 0, 4);
    chk("R2", raddr, BASE);
    pulse(1, 0);
    chk_state("R6", 0, 0, 4);
  endtask

  task automatic t_drain_and_block;
    pulse(0, 1); chk_state("R4", 0, 1, 3);
    chk("R2", raddr, BASE + 32'd1024);
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    chk_state("R4", 0, 0, 0);
    pulse(0, 1);
    chk_state("R7", 0, 0, 0);
  endtask

  task automatic t_simultaneous;
    pulse(1, 0); pulse(1, 0);
    pulse(1, 1); chk_state("R8", 3, 1, 2);
    pulse(1, 1); chk_state("R8", 0, 2, 2);
    pulse(0, 1); pulse(0, 1); chk_state("R8", 0, 0, 0);
    // empty: only write accepted
    pulse(1, 1); chk_state("R8", 1, 0, 1);
    pulse(0, 1);
    chk_state("R8", 1, 1, 0);
  endtask

  task automatic t_single;
    wd1 = 1; @(negedge clk); wd1 = 0;
    chk("R9", a1w, 0); chk("R9", a1r, 1); chk("R9", c1, 1);
    wd1 = 1; @(negedge clk); wd1 = 0;
    chk("R9", c1, 1); chk("R9", i1w, 0);
    rd1 = 1; @(negedge clk); rd1 = 0;
    chk("R9", a1w, 1); chk("R9", a1r, 0); chk("R9", ad1w, 32'h8000_0000);
  endtask

  task automatic t_pingpong;
    wd2 = 1; @(negedge clk); wd2 = 0;
    chk("R9", a2w, 1); chk("R9", i2w, 1); chk("R9", ad2w, 32'h8000_0200);
    wd2 = 1; @(negedge clk); wd2 = 0;
    chk("R9", a2w, 0); chk("R9", c2, 2);
    rd2 = 1; @(negedge clk); rd2 = 0;
    chk("R9", i2r, 1); chk("R9", a2w, 1); chk("R9", i2w, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_and_block();
    t_drain_and_block();
    t_simultaneous();
    t_single();
    t_pingpong();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule